// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block sits beside the reorder buffer of a multithreaded out-of-order core. It keeps one small state machine per hardware thread. Each cycle it decides whether that thread's buffer must be flushed and where the flush boundary lies. Three things can cause a flush:

- a trap that has waited out a programmable delay;
- a request to flush the whole thread context;
- a branch or memory-order squash reported by the execute stage.

For each flush it returns four things to the earlier pipeline stages: a one-cycle squash pulse, the boundary sequence number, a redirect PC, and the mispredict and taken bits. The reorder buffer itself is not part of the block. It appears only as three inputs per thread: a done-squashing flag, an empty flag and the head sequence number.

The block keeps, per thread, the youngest sequence number still valid. It accepts a squash from the execute stage only when the squashed sequence number is not younger than that value. A late squash from a younger instruction therefore never overrides a flush already taken for an older one. The block also gates the insertion of newly renamed instructions while a thread is flushing or waiting on a trap. It reports an empty buffer to the front end only once the stores have settled.

Each thread's machine has five states: `IDLE` (code 0), `RUNNING` (1), `ROB_SQUASHING` (2), `TRAP_PENDING` (3) and `FETCH_TRAP_PENDING` (4). The transitions are, in priority order:

1. Any state moves to `ROB_SQUASHING` on a full-thread squash.
2. Otherwise, any state moves to `TRAP_PENDING` or `FETCH_TRAP_PENDING` when a trap is raised.
3. Otherwise, any state moves to `ROB_SQUASHING` on an accepted execute squash.
4. Otherwise, `ROB_SQUASHING` moves to `RUNNING` when the buffer reports done.
5. Otherwise, `IDLE` moves to `RUNNING` on the first accepted insertion.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset, every thread is in state `IDLE` (code 0). At that point the squash pulse, squashing flag, trap-in-flight bit, youngest sequence number and mispredict count are all zero.
- R2: A trap raise is accepted only when no trap is in flight for that thread. On the next edge the thread enters `TRAP_PENDING` (3), or `FETCH_TRAP_PENDING` (4) if the fetch flag is set, and its trap-in-flight bit goes high. With latency L sampled at the raise edge, the full squash pulse appears after the edge L+1 cycles later. A raise while a trap is in flight is ignored.
- R3: A thread-context squash request takes effect at the next edge as a full squash. It is dropped if a trap is in flight or is raised in the same cycle, so that trap service always wins.
- R4: A full squash sets the boundary to head sequence number minus one, or to zero if the buffer is empty. It also sets the redirect PC to the thread's restart PC, clears the mispredict and taken bits, sets the youngest sequence number to zero, clears trap-in-flight and enters `ROB_SQUASHING`.
- R5: An execute squash is accepted only under three conditions: the thread is not in `TRAP_PENDING`, its sequence number is less than or equal to the youngest valid sequence number, and no full squash occurs in the same cycle. Otherwise it has no effect.
- R6: An accepted execute squash has the following effects. Its boundary is the squashed sequence number, or that number minus one (modulo 2^SEQ_W) when the squashing instruction is included. The youngest sequence number becomes the boundary. The redirect PC, mispredict bit and taken bit are echoed. The thread enters `ROB_SQUASHING`.
- R7: The squashing flag is high in every cycle the thread is in `ROB_SQUASHING`. The thread returns to `RUNNING` at the edge where done-squashing is sampled high, unless a new squash or trap occurs in that cycle.
- R8: An instruction is inserted (the accept output is high in the same cycle) only under three conditions: it is valid and not marked squashed, the thread is in neither `ROB_SQUASHING` nor `TRAP_PENDING`, and no squash is accepted in that cycle. Each insertion sets the youngest sequence number to the instruction's sequence number.
- R9: The empty report is registered. It is high only when, in the previous cycle, the buffer was empty, no stores awaited writeback and no store committed.
- R10: Each accepted execute squash with the mispredict bit set increments that thread's mispredict count, modulo 2^CNT_W. Nothing else changes the count.
- R11: A thread in `IDLE` moves to `RUNNING` on its first accepted insertion.
- R12: Threads are independent. Stimulus on one thread changes no output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_latency | input | LAT_W | Delay in cycles from trap raise to trap squash |
| trap_raise | input | NUM_THREADS | Raise a trap for the thread |
| trap_from_fetch | input | NUM_THREADS | Marks the raised trap as coming from fetch |
| ctx_squash_req | input | NUM_THREADS | Request a full thread-context squash |
| restart_pc | input | NUM_THREADS x PC_W | Redirect PC used by full squashes |
| ex_squash_valid | input | NUM_THREADS | Execute-stage squash request |
| ex_squash_seq | input | NUM_THREADS x SEQ_W | Sequence number of the squashing instruction |
| ex_include_self | input | NUM_THREADS | Squash includes the squashing instruction |
| ex_mispredict | input | NUM_THREADS | Squash caused by a branch mispredict |
| ex_taken | input | NUM_THREADS | Branch outcome taken |
| ex_redirect_pc | input | NUM_THREADS x PC_W | Redirect PC from execute |
| rob_done_squash | input | NUM_THREADS | Buffer has finished removing squashed entries |
| rob_empty | input | NUM_THREADS | Buffer holds no entries for the thread |
| rob_head_seq | input | NUM_THREADS x SEQ_W | Sequence number at the buffer head |
| stores_pending | input | NUM_THREADS | Stores still awaiting writeback |
| store_committed | input | NUM_THREADS | A store committed this cycle |
| ins_valid | input | NUM_THREADS | Incoming instruction present |
| ins_squashed | input | NUM_THREADS | Incoming instruction already squashed |
| ins_seq | input | NUM_THREADS x SEQ_W | Incoming instruction sequence number |
| ins_accept | output | NUM_THREADS | Instruction is inserted this cycle |
| squash_out | output | NUM_THREADS | One-cycle squash pulse to earlier stages |
| squashing_out | output | NUM_THREADS | Flush in progress |
| squash_boundary | output | NUM_THREADS x SEQ_W | Youngest surviving sequence number |
| redirect_pc | output | NUM_THREADS x PC_W | Restart PC for earlier stages |
| redirect_mispredict | output | NUM_THREADS | Squash was a mispredict |
| redirect_taken | output | NUM_THREADS | Branch taken bit of the squash |
| rob_empty_out | output | NUM_THREADS | Buffer reported empty to earlier stages |
| trap_in_flight | output | NUM_THREADS | A trap is waiting out its latency |
| thread_state | output | NUM_THREADS x 3 | State code of each thread |
| youngest_seq | output | NUM_THREADS x SEQ_W | Youngest valid sequence number |
| mispredict_count | output | NUM_THREADS x CNT_W | Accepted mispredict squashes, wrapping |

## Verification
The bench builds the block with two threads, 8-bit sequence numbers, 16-bit PCs, a 4-bit trap latency and a 3-bit mispredict count. With an 8-bit sequence, an included squash at sequence 0 wraps the boundary to 255 in a single step. With a 3-bit counter, nine mispredicts show the wrap of the count. Latencies of 0, 1 and 3 exercise the trap delay at its shortest and across several waiting cycles, including ignored raises and context requests while the trap waits. Using a second thread lets the bench confirm that flushes on one thread leave the other untouched.

// File: rtl/commit_sq_pkg.sv
package commit_sq_pkg;
    typedef enum logic [2:0] {
        TS_IDLE               = 3'd0,
        TS_RUNNING            = 3'd1,
        TS_ROB_SQUASHING      = 3'd2,
        TS_TRAP_PENDING       = 3'd3,
        TS_FETCH_TRAP_PENDING = 3'd4
    } thread_state_e;
endpackage

// File: rtl/commit_trap_delay.sv
module commit_trap_delay #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LAT_W-1:0] latency,
    output logic             fire,
    output logic             in_flight
);
    logic [LAT_W-1:0] remain_q;
    logic             busy_q;

    assign fire      = busy_q && (remain_q == '0);
    assign in_flight = busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
        end else if (arm && !busy_q) begin
            busy_q   <= 1'b1;
            remain_q <= latency;
        end else if (fire) begin
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // R2: an accepted raise loads the programmed delay and holds the flight bit
    assert_trap_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !busy_q) |=> (busy_q && remain_q == $past(latency)));

    // R4: servicing the trap clears the flight bit
    assert_fire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy_q);
endmodule

// File: rtl/commit_age_filter.sv
module commit_age_filter #(
    parameter int SEQ_W = 32
) (
    input  logic             ex_valid,
    input  logic             ex_include_self,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic [SEQ_W-1:0] youngest,
    input  logic             trap_pending,
    input  logic             full_squash,
    output logic             accept,
    output logic [SEQ_W-1:0] boundary
);
    logic older_or_same;

    always_comb begin
        older_or_same = (ex_seq <= youngest);
        accept        = ex_valid && !trap_pending && older_or_same && !full_squash;
        boundary      = ex_include_self ? (ex_seq - 1'b1) : ex_seq;
    end
endmodule

// File: rtl/commit_thread_ctrl.sv
module commit_thread_ctrl
    import commit_sq_pkg::*;
#(
    parameter int SEQ_W = 32,
    parameter int PC_W  = 32,
    parameter int LAT_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] trap_latency,
    input  logic             trap_raise,
    input  logic             trap_from_fetch,
    input  logic             ctx_req,
    input  logic [PC_W-1:0]  restart_pc,
    input  logic             ex_valid,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_include_self,
    input  logic             ex_mispredict,
    input  logic             ex_taken,
    input  logic [PC_W-1:0]  ex_pc,
    input  logic             rob_done,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] rob_head_seq,
    input  logic             stores_pending,
    input  logic             store_committed,
    input  logic             ins_valid,
    input  logic             ins_squashed,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             ins_accept,
    output logic             squash_pulse,
    output logic             squashing,
    output logic [SEQ_W-1:0] boundary,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             redirect_mispredict,
    output logic             redirect_taken,
    output logic             empty_report,
    output logic             trap_waiting,
    output logic [2:0]       state_code,
    output logic [SEQ_W-1:0] youngest,
    output logic [CNT_W-1:0] mispredict_count
);
    thread_state_e state_q, state_d;

    logic             trap_fire, in_flight;
    logic             raise_ok, ctx_ok, full_sq, ex_ok, ins_ok;
    logic [SEQ_W-1:0] ex_boundary;
    logic [SEQ_W-1:0] full_boundary;
    logic [SEQ_W-1:0] youngest_q;
    logic             sq_q, misp_q, taken_q, empty_q;
    logic [SEQ_W-1:0] boundary_q;
    logic [PC_W-1:0]  pc_q;
    logic [CNT_W-1:0] count_q;

    commit_trap_delay #(.LAT_W(LAT_W)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (raise_ok),
        .latency   (trap_latency),
        .fire      (trap_fire),
        .in_flight (in_flight)
    );

    commit_age_filter #(.SEQ_W(SEQ_W)) u_filter (
        .ex_valid        (ex_valid),
        .ex_include_self (ex_include_self),
        .ex_seq          (ex_seq),
        .youngest        (youngest_q),
        .trap_pending    (state_q == TS_TRAP_PENDING),
        .full_squash     (full_sq),
        .accept          (ex_ok),
        .boundary        (ex_boundary)
    );

    // squash source arbitration and next state
    always_comb begin
        raise_ok      = trap_raise && !in_flight;
        ctx_ok        = ctx_req && !in_flight && !trap_raise;
        full_sq       = trap_fire || ctx_ok;
        full_boundary = rob_empty ? '0 : (rob_head_seq - 1'b1);
        ins_ok        = ins_valid && !ins_squashed &&
                        (state_q != TS_ROB_SQUASHING) &&
                        (state_q != TS_TRAP_PENDING) &&
                        !full_sq && !ex_ok;
        state_d       = state_q;
        if (full_sq) begin
            state_d = TS_ROB_SQUASHING;
        end else if (raise_ok) begin
            state_d = trap_from_fetch ? TS_FETCH_TRAP_PENDING : TS_TRAP_PENDING;
        end else if (ex_ok) begin
            state_d = TS_ROB_SQUASHING;
        end else begin
            unique case (state_q)
                TS_IDLE:               if (ins_ok)   state_d = TS_RUNNING;
                TS_ROB_SQUASHING:      if (rob_done) state_d = TS_RUNNING;
                TS_RUNNING:            state_d = state_q;
                TS_TRAP_PENDING:       state_d = state_q;
                TS_FETCH_TRAP_PENDING: state_d = state_q;
                default:               state_d = TS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    // output and tracking registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q       <= 1'b0;
            boundary_q <= '0;
            pc_q       <= '0;
            misp_q     <= 1'b0;
            taken_q    <= 1'b0;
            youngest_q <= '0;
            count_q    <= '0;
            empty_q    <= 1'b0;
        end else begin
            sq_q    <= full_sq || ex_ok;
            empty_q <= rob_empty && !stores_pending && !store_committed;
            if (full_sq) begin
                boundary_q <= full_boundary;
                pc_q       <= restart_pc;
                misp_q     <= 1'b0;
                taken_q    <= 1'b0;
                youngest_q <= '0;
            end else if (ex_ok) begin
                boundary_q <= ex_boundary;
                pc_q       <= ex_pc;
                misp_q     <= ex_mispredict;
                taken_q    <= ex_taken;
                youngest_q <= ex_boundary;
                if (ex_mispredict) count_q <= count_q + 1'b1;
            end else if (ins_ok) begin
                youngest_q <= ins_seq;
            end
        end
    end

    assign ins_accept          = ins_ok;
    assign squash_pulse        = sq_q;
    assign squashing           = (state_q == TS_ROB_SQUASHING);
    assign boundary            = boundary_q;
    assign redirect_pc         = pc_q;
    assign redirect_mispredict = misp_q;
    assign redirect_taken      = taken_q;
    assign empty_report        = empty_q;
    assign trap_waiting        = in_flight;
    assign state_code          = state_q;
    assign youngest            = youngest_q;
    assign mispredict_count    = count_q;

    assert_full_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full_sq |=> (sq_q && youngest_q == '0 && !misp_q && state_q == TS_ROB_SQUASHING));

    assert_trap_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_TRAP_PENDING && !trap_fire) |=> !sq_q);

    assert_exec_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ok && ex_include_self) |=> (boundary_q == $past(ex_seq) - SEQ_W'(1)));

    assert_done_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_ROB_SQUASHING && rob_done && !full_sq && !ex_ok && !raise_ok)
        |=> (state_q == TS_RUNNING));

    assert_insert_youngest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ok |=> (youngest_q == $past(ins_seq)));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_ok && ex_mispredict) |=> $stable(count_q));
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 32,
    parameter int PC_W        = 32,
    parameter int LAT_W       = 8,
    parameter int CNT_W       = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LAT_W-1:0]                  trap_latency,
    input  logic [NUM_THREADS-1:0]            trap_raise,
    input  logic [NUM_THREADS-1:0]            trap_from_fetch,
    input  logic [NUM_THREADS-1:0]            ctx_squash_req,
    input  logic [NUM_THREADS-1:0][PC_W-1:0]  restart_pc,
    input  logic [NUM_THREADS-1:0]            ex_squash_valid,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0] ex_squash_seq,
    input  logic [NUM_THREADS-1:0]            ex_include_self,
    input  logic [NUM_THREADS-1:0]            ex_mispredict,
    input  logic [NUM_THREADS-1:0]            ex_taken,
    input  logic [NUM_THREADS-1:0][PC_W-1:0]  ex_redirect_pc,
    input  logic [NUM_THREADS-1:0]            rob_done_squash,
    input  logic [NUM_THREADS-1:0]            rob_empty,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0] rob_head_seq,
    input  logic [NUM_THREADS-1:0]            stores_pending,
    input  logic [NUM_THREADS-1:0]            store_committed,
    input  logic [NUM_THREADS-1:0]            ins_valid,
    input  logic [NUM_THREADS-1:0]            ins_squashed,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0] ins_seq,
    output logic [NUM_THREADS-1:0]            ins_accept,
    output logic [NUM_THREADS-1:0]            squash_out,
    output logic [NUM_THREADS-1:0]            squashing_out,
    output logic [NUM_THREADS-1:0][SEQ_W-1:0] squash_boundary,
    output logic [NUM_THREADS-1:0][PC_W-1:0]  redirect_pc,
    output logic [NUM_THREADS-1:0]            redirect_mispredict,
    output logic [NUM_THREADS-1:0]            redirect_taken,
    output logic [NUM_THREADS-1:0]            rob_empty_out,
    output logic [NUM_THREADS-1:0]            trap_in_flight,
    output logic [NUM_THREADS-1:0][2:0]       thread_state,
    output logic [NUM_THREADS-1:0][SEQ_W-1:0] youngest_seq,
    output logic [NUM_THREADS-1:0][CNT_W-1:0] mispredict_count
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        commit_thread_ctrl #(
            .SEQ_W (SEQ_W),
            .PC_W  (PC_W),
            .LAT_W (LAT_W),
            .CNT_W (CNT_W)
        ) u_ctrl (
            .clk                 (clk),
            .rst_n               (rst_n),
            .trap_latency        (trap_latency),
            .trap_raise          (trap_raise[t]),
            .trap_from_fetch     (trap_from_fetch[t]),
            .ctx_req             (ctx_squash_req[t]),
            .restart_pc          (restart_pc[t]),
            .ex_valid            (ex_squash_valid[t]),
            .ex_seq              (ex_squash_seq[t]),
            .ex_include_self     (ex_include_self[t]),
            .ex_mispredict       (ex_mispredict[t]),
            .ex_taken            (ex_taken[t]),
            .ex_pc               (ex_redirect_pc[t]),
            .rob_done            (rob_done_squash[t]),
            .rob_empty           (rob_empty[t]),
            .rob_head_seq        (rob_head_seq[t]),
            .stores_pending      (stores_pending[t]),
            .store_committed     (store_committed[t]),
            .ins_valid           (ins_valid[t]),
            .ins_squashed        (ins_squashed[t]),
            .ins_seq             (ins_seq[t]),
            .ins_accept          (ins_accept[t]),
            .squash_pulse        (squash_out[t]),
            .squashing           (squashing_out[t]),
            .boundary            (squash_boundary[t]),
            .redirect_pc         (redirect_pc[t]),
            .redirect_mispredict (redirect_mispredict[t]),
            .redirect_taken      (redirect_taken[t]),
            .empty_report        (rob_empty_out[t]),
            .trap_waiting        (trap_in_flight[t]),
            .state_code          (thread_state[t]),
            .youngest            (youngest_seq[t]),
            .mispredict_count    (mispredict_count[t])
        );
    end
endmodule

// File: tb/commit_squash_ctrl_test.sv
`timescale 1ns/1ps
module commit_squash_ctrl_test;
    localparam int NT = 2, SW = 8, PW = 16, LW = 4, CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [LW-1:0]          trap_latency;
    logic [NT-1:0]          trap_raise, trap_from_fetch, ctx_squash_req;
    logic [NT-1:0][PW-1:0]  restart_pc, ex_redirect_pc;
    logic [NT-1:0]          ex_squash_valid, ex_include_self, ex_mispredict, ex_taken;
    logic [NT-1:0][SW-1:0]  ex_squash_seq, rob_head_seq, ins_seq;
    logic [NT-1:0]          rob_done_squash, rob_empty, stores_pending, store_committed;
    logic [NT-1:0]          ins_valid, ins_squashed;
    logic [NT-1:0]          ins_accept, squash_out, squashing_out;
    logic [NT-1:0][SW-1:0]  squash_boundary, youngest_seq;
    logic [NT-1:0][PW-1:0]  redirect_pc;
    logic [NT-1:0]          redirect_mispredict, redirect_taken, rob_empty_out, trap_in_flight;
    logic [NT-1:0][2:0]     thread_state;
    logic [NT-1:0][CW-1:0]  mispredict_count;

    commit_squash_ctrl #(.NUM_THREADS(NT), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .trap_latency(trap_latency), .trap_raise(trap_raise),
        .trap_from_fetch(trap_from_fetch), .ctx_squash_req(ctx_squash_req),
        .restart_pc(restart_pc), .ex_squash_valid(ex_squash_valid),
        .ex_squash_seq(ex_squash_seq), .ex_include_self(ex_include_self),
        .ex_mispredict(ex_mispredict), .ex_taken(ex_taken), .ex_redirect_pc(ex_redirect_pc),
        .rob_done_squash(rob_done_squash), .rob_empty(rob_empty), .rob_head_seq(rob_head_seq),
        .stores_pending(stores_pending), .store_committed(store_committed),
        .ins_valid(ins_valid), .ins_squashed(ins_squashed), .ins_seq(ins_seq),
        .ins_accept(ins_accept), .squash_out(squash_out), .squashing_out(squashing_out),
        .squash_boundary(squash_boundary), .redirect_pc(redirect_pc),
        .redirect_mispredict(redirect_mispredict), .redirect_taken(redirect_taken),
        .rob_empty_out(rob_empty_out), .trap_in_flight(trap_in_flight),
        .thread_state(thread_state), .youngest_seq(youngest_seq),
        .mispredict_count(mispredict_count)
    );

    typedef struct packed {
        logic [0:0]    tid;
        logic [SW-1:0] bnd;
        logic [PW-1:0] pc;
        logic          misp;
        logic          taken;
    } exp_t;

    exp_t expq[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(int t, int b, int pc, bit m, bit tk);
        exp_t e;
        e.tid = 1'(t); e.bnd = SW'(b); e.pc = PW'(pc); e.misp = m; e.taken = tk;
        expq.push_back(e);
    endtask

    // monitor: compare each squash pulse against the scoreboard (R4, R6)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int t = 0; t < NT; t++) begin
                if (squash_out[t]) begin
                    if (expq.size() == 0) begin
                        chk("R5 unexpected squash", t, 99);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk("R4/R6 squash thread", t, e.tid);
                        chk("R4/R6 boundary", squash_boundary[t], e.bnd);
                        chk("R4/R6 redirect pc", redirect_pc[t], e.pc);
                        chk("R4/R6 mispredict", redirect_mispredict[t], e.misp);
                        chk("R4/R6 taken", redirect_taken[t], e.taken);
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clr();
        trap_raise = '0; trap_from_fetch = '0; ctx_squash_req = '0;
        ex_squash_valid = '0; ex_include_self = '0; ex_mispredict = '0; ex_taken = '0;
        rob_done_squash = '0; store_committed = '0; ins_valid = '0; ins_squashed = '0;
    endtask

    initial begin
        clr();
        trap_latency = '0; restart_pc = '0; ex_redirect_pc = '0; ex_squash_seq = '0;
        rob_head_seq = '0; ins_seq = '0; rob_empty = '0; stores_pending = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk("R1 state", thread_state, 0);
        chk("R1 squash", squash_out, 0);
        chk("R1 squashing", squashing_out, 0);
        chk("R1 youngest", youngest_seq, 0);
        chk("R1 count", mispredict_count, 0);
        chk("R1 trap", trap_in_flight, 0);

        // first insertion
        ins_valid[0] = 1; ins_seq[0] = 10; #1;
        chk("R8 accept", ins_accept[0], 1);
        tick(); clr();
        chk("R11 idle to running", thread_state[0], 1);
        chk("R8 youngest", youngest_seq[0], 10);

        // squashed instruction is not inserted
        ins_valid[0] = 1; ins_squashed[0] = 1; ins_seq[0] = 20; #1;
        chk("R8 squashed not accepted", ins_accept[0], 0);
        tick(); clr();
        chk("R8 youngest held", youngest_seq[0], 10);

        // younger execute squash ignored
        ex_squash_valid[0] = 1; ex_squash_seq[0] = 12;
        tick(); clr();
        chk("R5 younger ignored", squash_out[0], 0);
        chk("R5 state held", thread_state[0], 1);

        // accepted squash including self
        ex_squash_valid[0] = 1; ex_squash_seq[0] = 7; ex_include_self[0] = 1;
        ex_mispredict[0] = 1; ex_taken[0] = 1; ex_redirect_pc[0] = 16'h1234;
        push(0, 6, 16'h1234, 1, 1);
        tick(); clr();
        chk("R6 state", thread_state[0], 2);
        chk("R7 squashing", squashing_out[0], 1);
        chk("R6 youngest", youngest_seq[0], 6);
        chk("R10 count", mispredict_count[0], 1);

        // insertion blocked while flushing
        ins_valid[0] = 1; ins_seq[0] = 30; #1;
        chk("R8 blocked in squashing", ins_accept[0], 0);
        tick(); clr();
        chk("R7 squashing held", squashing_out[0], 1);
        chk("R8 youngest kept", youngest_seq[0], 6);
        rob_done_squash[0] = 1;
        tick(); clr();
        chk("R7 back to running", thread_state[0], 1);
        chk("R7 flag low", squashing_out[0], 0);

        // equal sequence accepted, no mispredict
        ex_squash_valid[0] = 1; ex_squash_seq[0] = 6; ex_redirect_pc[0] = 16'h2222;
        push(0, 6, 16'h2222, 0, 0);
        tick(); clr();
        chk("R5 equal accepted", thread_state[0], 2);
        chk("R10 count unchanged", mispredict_count[0], 1);
        rob_done_squash[0] = 1; tick(); clr();

        // trap with latency 3
        rob_head_seq[0] = 50; rob_empty[0] = 0; restart_pc[0] = 16'h0400;
        trap_latency = 3; trap_raise[0] = 1;
        push(0, 49, 16'h0400, 0, 0);
        tick(); clr();
        chk("R2 trap pending", thread_state[0], 3);
        chk("R2 in flight", trap_in_flight[0], 1);
        chk("R2 no early squash", squash_out[0], 0);
        ex_squash_valid[0] = 1; ex_squash_seq[0] = 1;
        trap_raise[0] = 1; trap_latency = 0;
        tick(); clr();
        chk("R2 second raise ignored", squash_out[0], 0);
        chk("R5 exec blocked in trap", thread_state[0], 3);
        ctx_squash_req[0] = 1; ins_valid[0] = 1; ins_seq[0] = 40; #1;
        chk("R8 blocked in trap", ins_accept[0], 0);
        tick(); clr();
        chk("R3 ctx dropped", squash_out[0], 0);
        tick();
        chk("R2 still waiting", squash_out[0], 0);
        chk("R2 flight held", trap_in_flight[0], 1);
        tick();
        chk("R2 squash after latency", squash_out[0], 1);
        chk("R4 youngest zero", youngest_seq[0], 0);
        chk("R4 state", thread_state[0], 2);
        chk("R4 flight cleared", trap_in_flight[0], 0);
        rob_done_squash[0] = 1; tick(); clr();

        // context squash with empty buffer
        rob_empty[0] = 1; restart_pc[0] = 16'h0800; ctx_squash_req[0] = 1;
        push(0, 0, 16'h0800, 0, 0);
        tick(); clr();
        chk("R3 ctx squash", squash_out[0], 1);
        chk("R4 empty boundary", squash_boundary[0], 0);
        rob_done_squash[0] = 1; tick(); clr();

        // fetch trap, latency 0
        rob_empty[0] = 0; rob_head_seq[0] = 20; restart_pc[0] = 16'h0900;
        trap_latency = 0; trap_raise[0] = 1; trap_from_fetch[0] = 1;
        push(0, 19, 16'h0900, 0, 0);
        tick(); clr();
        chk("R2 fetch trap state", thread_state[0], 4);
        chk("R2 latency0 not yet", squash_out[0], 0);
        tick();
        chk("R2 latency0 squash", squash_out[0], 1);
        rob_done_squash[0] = 1; tick(); clr();

        // raise and context request together
        rob_head_seq[0] = 30; restart_pc[0] = 16'h0A00; trap_latency = 1;
        trap_raise[0] = 1; ctx_squash_req[0] = 1;
        push(0, 29, 16'h0A00, 0, 0);
        tick(); clr();
        chk("R3 ctx loses to raise", squash_out[0], 0);
        chk("R3 trap state", thread_state[0], 3);
        tick();
        chk("R2 latency1 wait", squash_out[0], 0);
        tick();
        chk("R2 latency1 squash", squash_out[0], 1);
        rob_done_squash[0] = 1; tick(); clr();

        // empty report
        rob_empty[0] = 1; stores_pending[0] = 0;
        tick();
        chk("R9 empty", rob_empty_out[0], 1);
        store_committed[0] = 1; tick(); clr();
        chk("R9 store committed", rob_empty_out[0], 0);
        stores_pending[0] = 1; tick();
        chk("R9 stores pending", rob_empty_out[0], 0);
        stores_pending[0] = 0; rob_empty[0] = 0;

        // counter wrap
        ins_valid[0] = 1; ins_seq[0] = 100; tick(); clr();
        chk("R8 youngest 100", youngest_seq[0], 100);
        for (int i = 0; i < 8; i++) begin
            ex_squash_valid[0] = 1; ex_squash_seq[0] = 100; ex_mispredict[0] = 1;
            ex_redirect_pc[0] = PW'(16'h3000 + i);
            push(0, 100, 16'h3000 + i, 1, 0);
            tick(); clr();
        end
        chk("R10 count wrap", mispredict_count[0], 1);
        rob_done_squash[0] = 1; tick(); clr();

        // second thread independent, boundary wrap
        chk("R12 thread1 idle", thread_state[1], 0);
        chk("R12 thread1 count", mispredict_count[1], 0);
        ex_squash_valid[1] = 1; ex_squash_seq[1] = 0; ex_include_self[1] = 1;
        ex_taken[1] = 1; ex_redirect_pc[1] = 16'h5555;
        push(1, 255, 16'h5555, 0, 1);
        tick(); clr();
        chk("R6 wrap youngest", youngest_seq[1], 255);
        chk("R12 thread1 squashing", thread_state[1], 2);
        chk("R12 thread0 untouched", thread_state[0], 1);
        chk("R12 thread0 no squash", squash_out[0], 0);

        tick(); tick();
        chk("R4/R6 scoreboard drained", expq.size(), 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule